// File: doc/BRIEF.md
# Prescaled 64-bit Timer with Coherent Read

The block is one timer channel. It joins a 32-bit prescale counter (the low word) and a 32-bit free-running counter (the high word) into a single 64-bit time base. The low word advances on every enabled timer clock. When it reaches a programmable limit, it returns to zero and the high word steps up by one in the same clock edge. A compare value of zero selects the full 2^32 prescale, so the 64-bit value then counts every clock with no gap.

Software reaches the channel through a simple register port. Each request is one cycle, and a read returns its data one cycle later. Reading the high word also copies the live low word into a shadow register. A later low-word read returns that copy, so reading the high word first and the low word second yields one consistent 64-bit sample. The counters and the limit can be written only while counting is switched off. A control bit decides whether the channel keeps counting or stands still while the debug halt input is high.

Top module: `wide_tick_timer`

## Requirements
- R1: After reset, both counters, the limit register and both control bits are zero. Reads of all four registers return zero, and `rd_data` is zero before the first read.
- R2: While a tick is active and the low word is below its limit, the low word increases by one on each clock and the high word is unchanged.
- R3: With a nonzero limit N (register select 3), the low word counts 0 through N and then returns to 0. The high word therefore increments once every N+1 ticks.
- R4: With limit 0, the low word runs through all 2^32 values. Its step from 0xFFFFFFFF to 0 and the high-word increment happen on the same clock edge, so a coherent 64-bit read never steps back or skips.
- R5: With limit 0xFFFFFFFF, the 64-bit value behaves exactly as in R4.
- R6: A read of the high word (select 1) returns the live high word and copies the live low word from the same edge into a shadow. A read of the low word (select 2) returns the shadow, not the live count. Read data appears on `rd_data` one cycle after the request.
- R7: Control bit 0 (select 0) enables counting. While it is 0, neither counter changes.
- R8: Writes to the high word, the low word or the limit take effect only while bit 0 is 0. While counting is enabled they are ignored. The control register is always writable.
- R9: Control bit 1 set lets counting continue while `halt_i` is high. With bit 1 clear and `halt_i` high, both counters hold.
- R10: Writing the low word also sets the prescale phase, so the next wrap happens after (limit - written value + 1) ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_i | input | 1 | Debug halt request |
| req_valid | input | 1 | Register request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | Register select: 0 control, 1 high word, 2 low word, 3 limit |
| req_wdata | input | W | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | W | Registered read data |

## Verification
Two things can land on the same clock edge: the low-word wrap (with its high-word increment) and the high-word read that takes the snapshot. The bench provokes this by loading the low word a few counts below 0xFFFFFFFF, with the limit at zero and then at all ones, and starting from two preload values of different parity. It then reads the 64-bit value back to back, so that a high-word read falls exactly on the wrap edge. Every sample is checked against the value predicted from the number of elapsed clocks, and every difference between consecutive samples must equal the two cycles one coherent read takes.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int SEL_W = 2;
  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_HI   = 2'd1,
    SEL_LO   = 2'd2,
    SEL_CMP  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         halt_i,
  input  logic         req_valid,
  input  logic         req_write,
  input  reg_sel_e     sel,
  input  logic [W-1:0] wdata,
  output logic         run_en,
  output logic         halt_run,
  output logic [W-1:0] cmp,
  output logic         tick,
  output logic         ld_lo,
  output logic         ld_hi
);
  logic wr;
  assign wr    = req_valid && req_write;
  assign ld_lo = wr && (sel == SEL_LO) && !run_en;
  assign ld_hi = wr && (sel == SEL_HI) && !run_en;
  assign tick  = run_en && (halt_run || !halt_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_en   <= 1'b0;
      halt_run <= 1'b0;
      cmp      <= '0;
    end else begin
      if (wr && sel == SEL_CTRL) begin
        run_en   <= wdata[0];
        halt_run <= wdata[1];
      end
      if (wr && sel == SEL_CMP && !run_en)
        cmp <= wdata;
    end
  end

  // R8: limit locked while counting
  a_r8_cmp_locked: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_CMP && run_en) |=> $stable(cmp));
endmodule

// File: rtl/timer_count_core.sv
module timer_count_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] cmp,
  input  logic         ld_lo,
  input  logic         ld_hi,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  logic [W-1:0] limit;
  logic         at_limit;

  // zero limit selects the full-width prescale
  assign limit    = (cmp == '0) ? '1 : cmp;
  assign at_limit = (lo == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo <= '0;
      hi <= '0;
    end else begin
      if (ld_lo)
        lo <= wdata;
      else if (tick)
        lo <= at_limit ? '0 : lo + 1'b1;
      if (ld_hi)
        hi <= wdata;
      else if (tick && at_limit)
        hi <= hi + 1'b1;
    end
  end

  // R4 R5: wrap and high increment on the same edge
  a_r4_same_edge: assert property (@(posedge clk) disable iff (rst)
    (tick && at_limit && !ld_lo && !ld_hi) |=> (lo == '0 && hi == $past(hi) + 1'b1));
  // R2: plain step
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !at_limit && !ld_lo && !ld_hi) |=> (lo == $past(lo) + 1'b1 && hi == $past(hi)));
  // R7: hold without tick
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld_lo && !ld_hi) |=> ($stable(lo) && $stable(hi)));
endmodule

// File: rtl/timer_read_port.sv
module timer_read_port
  import timer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_req,
  input  reg_sel_e     sel,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] cmp,
  input  logic         run_en,
  input  logic         halt_run,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] snap;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      snap     <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        case (sel)
          SEL_CTRL: rd_data <= {{(W-2){1'b0}}, halt_run, run_en};
          SEL_HI: begin
            rd_data <= hi;
            snap    <= lo;
          end
          SEL_LO:  rd_data <= snap;
          SEL_CMP: rd_data <= cmp;
          default: rd_data <= '0;
        endcase
      end
    end
  end

  // R6: high read pairs with low snapshot from the same edge
  a_r6_pair: assert property (@(posedge clk) disable iff (rst)
    (rd_req && sel == SEL_HI) |=> (snap == $past(lo) && rd_data == $past(hi)));
  // R6: low read returns the shadow
  a_r6_shadow: assert property (@(posedge clk) disable iff (rst)
    (rd_req && sel == SEL_LO) |=> (rd_data == $past(snap)));
endmodule

// File: rtl/wide_tick_timer.sv
module wide_tick_timer
  import timer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt_i,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [SEL_W-1:0] req_sel,
  input  logic [W-1:0]     req_wdata,
  output logic             rd_valid,
  output logic [W-1:0]     rd_data
);
  reg_sel_e     sel;
  logic         run_en, halt_run, tick, ld_lo, ld_hi, rd_req;
  logic [W-1:0] cmp, lo, hi;

  assign sel    = reg_sel_e'(req_sel);
  assign rd_req = req_valid && !req_write;

  timer_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .halt_i(halt_i), .req_valid(req_valid),
    .req_write(req_write), .sel(sel), .wdata(req_wdata), .run_en(run_en),
    .halt_run(halt_run), .cmp(cmp), .tick(tick), .ld_lo(ld_lo), .ld_hi(ld_hi)
  );

  timer_count_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .cmp(cmp), .ld_lo(ld_lo),
    .ld_hi(ld_hi), .wdata(req_wdata), .lo(lo), .hi(hi)
  );

  timer_read_port #(.W(W)) u_rd (
    .clk(clk), .rst(rst), .rd_req(rd_req), .sel(sel), .lo(lo), .hi(hi),
    .cmp(cmp), .run_en(run_en), .halt_run(halt_run),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // R9: halt freezes counting unless allowed
  a_r9_halt_freeze: assert property (@(posedge clk) disable iff (rst)
    (run_en && halt_i && !halt_run) |=> ($stable(lo) && $stable(hi)));
endmodule

// File: tb/tb_wide_tick_timer.sv
module tb_wide_tick_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         halt_i = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic [1:0]   req_sel = 2'd0;
  logic [W-1:0] req_wdata = '0;
  logic         rd_valid;
  logic [W-1:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_tick_timer #(.W(W)) dut (
    .clk(clk), .rst(rst), .halt_i(halt_i), .req_valid(req_valid),
    .req_write(req_write), .req_sel(req_sel), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // all bus tasks start and end just after a falling edge
  task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_sel = s; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [W-1:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_sel = s;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    d = rd_data;
  endtask

  task automatic rd64(output logic [63:0] v);
    logic [W-1:0] h, l;
    rd(2'd1, h);
    rd(2'd2, l);
    v = {h, l};
  endtask

  task automatic preload(input logic [W-1:0] lo, input logic [W-1:0] hi, input logic [W-1:0] lim);
    wr(2'd0, 0);
    wr(2'd2, lo);
    wr(2'd1, hi);
    wr(2'd3, lim);
  endtask

  task automatic t_reset();
    logic [W-1:0] d;
    chk("R1 rd_data", {32'd0, rd_data}, 64'd0);
    for (int s = 0; s < 4; s++) begin
      rd(s[1:0], d);
      chk("R1 reg", {32'd0, d}, 64'd0);
    end
  endtask

  task automatic t_prescale();
    logic [63:0] v;
    int p;
    preload(32'd2, 32'd0, 32'd4);
    wr(2'd0, 32'd1);
    for (int k = 0; k < 8; k++) begin
      rd64(v);
      p = 2 + 2 * k;
      chk("R3 R10 R2", v, {32'(p / 5), 32'(p % 5)});
    end
  endtask

  task automatic t_roll(input string tag, input logic [W-1:0] lim, input logic [W-1:0] lo);
    logic [63:0] v, prev, base;
    base = {32'h0000_000a, lo};
    preload(lo, 32'h0000_000a, lim);
    wr(2'd0, 32'd1);
    prev = '0;
    for (int k = 0; k < 16; k++) begin
      rd64(v);
      chk(tag, v, base + 64'(2 * k));
      if (k > 0) chk({tag, " step"}, v - prev, 64'd2);
      prev = v;
    end
  endtask

  task automatic t_snapshot();
    logic [W-1:0] h, l;
    logic [63:0] v;
    preload(32'd0, 32'd0, 32'd0);
    wr(2'd0, 32'd1);
    rd(2'd1, h);
    repeat (10) @(negedge clk);
    rd(2'd2, l);
    chk("R6 shadow", {h, l}, 64'd0);
    rd64(v);
    chk("R6 live pair", v, 64'd12);
  endtask

  task automatic t_lock();
    logic [63:0] v;
    logic [W-1:0] c;
    preload(32'd100, 32'd7, 32'hffff_ffff);
    wr(2'd0, 32'd1);
    wr(2'd2, 32'd5);
    wr(2'd3, 32'd7);
    wr(2'd0, 32'd0);
    rd64(v);
    chk("R8 count write ignored", v, {32'd7, 32'd103});
    rd(2'd3, c);
    chk("R8 limit write ignored", {32'd0, c}, 64'h0000_0000_ffff_ffff);
    repeat (5) @(negedge clk);
    rd64(v);
    chk("R7 frozen while disabled", v, {32'd7, 32'd103});
  endtask

  task automatic t_halt();
    logic [63:0] a, b;
    logic [W-1:0] c;
    preload(32'd0, 32'd0, 32'd0);
    halt_i = 1'b1;
    wr(2'd0, 32'd1);
    rd64(a);
    rd64(b);
    chk("R9 halted hold", a, 64'd0);
    chk("R9 halted delta", b - a, 64'd0);
    halt_i = 1'b0;
    rd64(a);
    rd64(b);
    chk("R9 released delta", b - a, 64'd2);
    wr(2'd0, 32'd3);
    halt_i = 1'b1;
    rd64(a);
    rd64(b);
    chk("R9 run in halt delta", b - a, 64'd2);
    rd(2'd0, c);
    chk("R9 ctrl readback", {32'd0, c}, 64'd3);
    halt_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_prescale();
    t_roll("R4", 32'd0, 32'hffff_fff0);
    t_roll("R4", 32'd0, 32'hffff_fff1);
    t_roll("R5", 32'hffff_ffff, 32'hffff_fff0);
    t_roll("R5", 32'hffff_ffff, 32'hffff_fff1);
    t_snapshot();
    t_lock();
    t_halt();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule